// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Flag

This block carries data words from a write clock domain to a read clock domain whose clock has no fixed relation to it. The storage is a power-of-two array of `2**AW` words. The read and write pointers are exactly `AW` bits wide, with no extra wrap bit. When the two pointers are equal, a direction flag says whether the array is full or empty.

Each side keeps its own copy of the direction flag. The copy moves toward "going full" or "going empty" from the top two Gray-coded bits of the local pointer and of the synchronized remote pointer. Those two bits place each pointer in one of four quadrants. Each side also watches for the remote pointer landing exactly on the local one. If that happens, the remote side must have caused it, and the flag takes the matching meaning.

Every pointer is a binary counter that addresses the array. A registered Gray copy of it crosses into the other domain through two flip-flops. The full output is registered in the write domain and the empty output in the read domain. A producer pushes while `full` is low. A consumer pops while `empty` is low and takes the word on the next read clock.

Top module: `afq_fifo`

## Requirements
- R1: While `wr_rst` is high, `full` goes to 0. While `rd_rst` is high, `empty` goes to 1. Both values hold once reset is released and no traffic has occurred.
- R2: Every accepted word comes out of `rd_data` exactly once, in acceptance order. This holds across many pointer wraps and for both a faster and a slower read clock.
- R3: With no reads, `full` rises on the write clock edge that accepts the `2**AW`-th word, and stays 0 after `2**AW`-1 words. A push while `full` is 1 does not move the write pointer and does not change stored data.
- R4: `empty` rises on the read clock edge that accepts the pop of the last stored word. A pop while `empty` is 1 does not move the read pointer and leaves `rd_data` unchanged.
- R5: `rd_data` takes the popped word on the read clock edge that accepts the pop. It holds its value on every other read clock edge.
- R6: A push into an empty FIFO drives `empty` low within 4 read clock cycles. A pop from a full FIFO drives `full` low within 4 write clock cycles. The pointer copy that crosses domains changes by at most one bit per clock.
- R7: When the pointers are equal, the direction flag decides the meaning. After `2**AW` words are written and the read side has seen them, `empty` is 0 while `full` is 1. After everything is read and the write side has seen it, `full` is 0 while `empty` is 1.
- R8: Under any ratio of clock rates and any push/pop pattern, the write side never holds more than `2**AW` words. The read side never drops `empty` while no unread word exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| push | input | 1 | Write request; taken when `full` is 0 |
| wr_data | input | DW | Word to store |
| full | output | 1 | Registered full indication, write domain |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| pop | input | 1 | Read request; taken when `empty` is 0 |
| rd_data | output | DW | Word removed by the last accepted pop |
| empty | output | 1 | Registered empty indication, read domain |

## Verification
A direction flag holding the wrong meaning shows at the ports as soon as the pointers meet. If it says full when the FIFO is empty, the write side locks up and `full` never falls after the drain. If it says empty when the FIFO is full, the read side stops early or lets the writer overwrite unread words. The reference queue then flags a missing or out-of-order word on the very next pop. A broken quadrant test or catch rule usually appears only after a pointer wraps. So traffic runs many times around the array with the read clock both faster and slower, and the exact full and empty edges are timed against the boundary counts.

// File: rtl/afq_pkg.sv
package afq_pkg;

    // Meaning of pointer equality as seen by one side.
    typedef enum logic {
        DIR_EMPTY = 1'b0,
        DIR_FULL  = 1'b1
    } dir_e;

    // Events that move a side's direction flag.
    typedef struct packed {
        logic chase;     // local pointer one quadrant behind the remote one
        logic lead;      // remote pointer one quadrant behind the local one
        logic catch_up;  // remote pointer moved and now equals the local one
    } quad_ev_t;

    // True when Gray quadrant a sits exactly one quadrant behind Gray quadrant b.
    function automatic logic quad_behind(input logic [1:0] a, input logic [1:0] b);
        return (a[1] ^ b[0]) & ~(a[0] ^ b[1]);
    endfunction

    function automatic dir_e dir_update(input quad_ev_t ev, input dir_e cur,
                                        input dir_e close_v, input dir_e open_v);
        if (ev.chase)
            return close_v;
        if (ev.lead || ev.catch_up)
            return open_v;
        return cur;
    endfunction

endpackage

// File: rtl/afq_sync.sv
module afq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++)
                st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/afq_side.sv
// One pointer side: binary counter, registered Gray copy, local direction
// flag and the registered blocking output (full for writer, empty for reader).
module afq_side
    import afq_pkg::*;
#(
    parameter int AW    = 4,
    parameter bit IS_WR = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] rem_gray,
    output logic          step,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] gray,
    output logic          blocked
);
    localparam dir_e CLOSE_V = IS_WR ? DIR_FULL : DIR_EMPTY;
    localparam dir_e OPEN_V  = IS_WR ? DIR_EMPTY : DIR_FULL;
    localparam logic BLK_RST = IS_WR ? 1'b0 : 1'b1;

    logic [AW-1:0] bin_q, gray_q, seen_q;
    logic [AW-1:0] bin_nx, gray_nx;
    dir_e          dir_q, dir_nx;
    logic          blk_q, blk_nx, eq_nx;
    logic [1:0]    lq, mq;
    quad_ev_t      ev;

    always_comb begin
        step        = req & ~blk_q;
        bin_nx      = bin_q + AW'(step);
        gray_nx     = bin_nx ^ (bin_nx >> 1);
        lq          = gray_nx[AW-1:AW-2];
        mq          = rem_gray[AW-1:AW-2];
        eq_nx       = (gray_nx == rem_gray);
        ev.chase    = quad_behind(lq, mq);
        ev.lead     = quad_behind(mq, lq);
        ev.catch_up = eq_nx && (rem_gray != seen_q);
        dir_nx      = dir_update(ev, dir_q, CLOSE_V, OPEN_V);
        blk_nx      = eq_nx && (dir_nx == CLOSE_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
            seen_q <= '0;
            dir_q  <= DIR_EMPTY;
            blk_q  <= BLK_RST;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= gray_nx;
            seen_q <= rem_gray;
            dir_q  <= dir_nx;
            blk_q  <= blk_nx;
        end
    end

    assign addr    = bin_q;
    assign gray    = gray_q;
    assign blocked = blk_q;
endmodule

// File: rtl/afq_mem.sv
module afq_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)
            rdata <= '0;
        else if (re)
            rdata <= cells[raddr];
    end
endmodule

// File: rtl/afq_fifo.sv
module afq_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          push,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    localparam int SYNC_STAGES = 2;

    logic [AW-1:0] w_addr, r_addr, w_gray, r_gray, r_gray_at_w, w_gray_at_r;
    logic          w_step, r_step;

    if (AW < 2) begin : g_bad_width
        $error("afq_fifo needs AW >= 2 for quadrant logic");
    end

    afq_side #(.AW(AW), .IS_WR(1'b1)) u_wside (
        .clk(wr_clk), .rst(wr_rst), .req(push), .rem_gray(r_gray_at_w),
        .step(w_step), .addr(w_addr), .gray(w_gray), .blocked(full)
    );

    afq_side #(.AW(AW), .IS_WR(1'b0)) u_rside (
        .clk(rd_clk), .rst(rd_rst), .req(pop), .rem_gray(w_gray_at_r),
        .step(r_step), .addr(r_addr), .gray(r_gray), .blocked(empty)
    );

    afq_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(w_gray), .q(w_gray_at_r)
    );

    afq_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(r_gray), .q(r_gray_at_w)
    );

    afq_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk(wr_clk), .we(w_step), .waddr(w_addr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(r_step), .raddr(r_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/afq_fifo_chk.sv
module afq_fifo_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_rst,
    input logic          rd_rst,
    input logic          pop,
    input logic          full,
    input logic          empty,
    input logic [AW-1:0] w_addr,
    input logic [AW-1:0] r_addr,
    input logic [AW-1:0] w_gray,
    input logic [AW-1:0] r_gray,
    input logic [DW-1:0] rd_data
);
    AST_WR_RESET_FLAG: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(wr_rst) |-> !full); // R1
    AST_RD_RESET_FLAG: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_rst) |-> empty); // R1
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |=> $stable(w_addr)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        empty |=> $stable(r_addr)); // R4
    AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(pop && !empty) |=> $stable(rd_data)); // R5
    AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(w_gray ^ $past(w_gray)) <= 1); // R6
    AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(r_gray ^ $past(r_gray)) <= 1); // R6
endmodule

bind afq_fifo afq_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
    .pop(pop), .full(full), .empty(empty),
    .w_addr(w_addr), .r_addr(r_addr), .w_gray(w_gray), .r_gray(r_gray),
    .rd_data(rd_data)
);

// File: tb/sim_afq_fifo.sv
`timescale 1ns/1ps
module sim_afq_fifo;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic wclk = 0, rclk = 0, wrst = 1, rrst = 1, push = 0, pop = 0;
    logic [DW-1:0] wdata = '0;
    logic full, empty;
    logic [DW-1:0] rdata;
    real rhalf = 5.3;
    int n_chk = 0, n_err = 0;
    bit done = 0, wdone = 0;
    logic [DW-1:0] q[$];
    logic wfull_prev = 1, rempty_prev = 1;
    logic [DW-1:0] last_rd = '0, exp_v;

    always #4 wclk = ~wclk;          // 125 MHz write clock
    always #(rhalf) rclk = ~rclk;    // read clock, rate changed per phase

    afq_fifo #(.DW(DW), .AW(AW)) u0 (
        .wr_clk(wclk), .wr_rst(wrst), .push(push), .wr_data(wdata), .full(full),
        .rd_clk(rclk), .rd_rst(rrst), .pop(pop), .rd_data(rdata), .empty(empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Write-side reference: record every accepted word.
    always @(negedge wclk) begin
        if (!wrst && push && !wfull_prev) begin
            chk(q.size() < DEPTH, "R8", "write accepted beyond depth", q.size(), DEPTH - 1);
            q.push_back(wdata);
        end
        wfull_prev = wrst ? 1'b1 : full;
    end

    // Read-side reference: compare each popped word, check holds.
    always @(negedge rclk) begin
        if (!rrst) begin
            if (pop && !rempty_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "pop accepted with nothing written", 0, 1);
                end else begin
                    exp_v = q.pop_front();
                    chk(rdata == exp_v, "R2", "read order", rdata, exp_v);
                end
            end else if (pop) begin
                chk(rdata == last_rd, "R4", "pop while empty changed data", rdata, last_rd);
            end else begin
                chk(rdata == last_rd, "R5", "rdata not held", rdata, last_rd);
            end
            if (!empty)
                chk(q.size() > 0, "R8", "empty low with no unread word", q.size(), 1);
        end
        rempty_prev = rrst ? 1'b1 : empty;
        last_rd = rdata;
    end

    initial begin
        int n;
        repeat (6) @(negedge wclk);
        #1 wrst = 0;
        @(negedge rclk);
        #1 rrst = 0;
        repeat (3) @(negedge wclk);
        chk(full == 1'b0, "R1", "full after reset", full, 0);
        @(negedge rclk);
        chk(empty == 1'b1, "R1", "empty after reset", empty, 1);

        // Fill past depth with the reader idle.
        for (int i = 0; i < DEPTH + 3; i++) begin
            @(negedge wclk);
            if (i == DEPTH - 1) chk(full == 1'b0, "R3", "full one word early", full, 0);
            if (i == DEPTH)     chk(full == 1'b1, "R3", "full at depth", full, 1);
            #1 push = 1; wdata = DW'(i * 7 + 3);
        end
        @(negedge wclk);
        #1 push = 0;
        repeat (10) @(negedge rclk);
        chk(empty == 1'b0, "R7", "read side sees full FIFO as empty", empty, 0);
        chk(full == 1'b1, "R7", "write side lost full", full, 1);

        // One pop, then time the release of full.
        @(negedge rclk);
        #(rhalf / 2) pop = 1;
        @(negedge rclk);
        #(rhalf / 2) pop = 0;
        n = 0;
        while (full && n < 10) begin
            @(negedge wclk);
            n++;
        end
        chk(!full && n <= 4, "R6", "full release latency (wclk)", n, 4);

        // Drain the rest plus extra pops on empty.
        for (int j = 0; j < DEPTH + 2; j++) begin
            @(negedge rclk);
            if (j == DEPTH - 2) chk(empty == 1'b0, "R4", "empty one word early", empty, 0);
            if (j == DEPTH - 1) chk(empty == 1'b1, "R4", "empty after last word", empty, 1);
            #(rhalf / 2) pop = 1;
        end
        @(negedge rclk);
        #(rhalf / 2) pop = 0;
        repeat (10) @(negedge wclk);
        chk(full == 1'b0, "R7", "write side sees empty FIFO as full", full, 0);

        // Single push into empty FIFO, time the release of empty.
        @(negedge wclk);
        #1 push = 1; wdata = 8'hA5;
        @(negedge wclk);
        #1 push = 0;
        n = 0;
        while (empty && n < 10) begin
            @(negedge rclk);
            n++;
        end
        chk(!empty && n <= 4, "R6", "empty release latency (rclk)", n, 4);
        @(negedge rclk);
        #(rhalf / 2) pop = 1;
        @(negedge rclk);
        #(rhalf / 2) pop = 0;

        // Random traffic: fast reader, then slow reader.
        for (int ph = 0; ph < 2; ph++) begin
            rhalf = (ph == 0) ? 1.7 : 13.3;
            wdone = 0;
            repeat (4) @(negedge rclk);
            fork
                begin
                    repeat (3000) begin
                        @(negedge wclk);
                        #1 push = ($urandom % 100) < ((ph == 0) ? 35 : 80);
                        wdata = DW'($urandom);
                    end
                    @(negedge wclk);
                    #1 push = 0;
                    wdone = 1;
                end
                begin
                    while (!wdone) begin
                        @(negedge rclk);
                        #(rhalf / 2) pop = ($urandom % 100) < ((ph == 0) ? 30 : 85);
                    end
                end
            join
            for (int k = 0; k < 3000 && (q.size() > 0 || !empty); k++) begin
                @(negedge rclk);
                #(rhalf / 2) pop = 1;
            end
            @(negedge rclk);
            #(rhalf / 2) pop = 0;
            repeat (6) @(negedge rclk);
            chk(q.size() == 0, "R2", "words never delivered", q.size(), 0);
            chk(empty == 1'b1, "R7", "empty after drain", empty, 1);
            repeat (6) @(negedge wclk);
            chk(full == 1'b0, "R7", "full after drain", full, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule